// File: doc/BRIEF.md
# PWM Shutdown Controller

This block gathers every reason to stop a three-phase inverter into a single shutdown condition. Three kinds of source can request it: an active-low trip pin, a bank of general-purpose I/O lines that each count as a trip only when their bit in an enable mask is set, and a write strobe from software. A hardware trip forces all six gate outputs to their off level through gates alone, so the inverter is made safe even when the clock has stopped.

In parallel with that path, the trip pin and the I/O lines pass through a flop synchronizer into a clocked shutdown latch. The latch keeps the gates off and the PWM timer in reset after the source has gone away. It sends a single-cycle interrupt when it sets. It is released only when software writes a clear while no hardware source is asserted. The synchronized level of the trip pin is also brought out as a status bit.

The chip reset tree drives `rst_n`. It may assert `rst_n` at any time, but it releases it in step with `clk`.

Top module: `pwm_trip_ctrl`

## Requirements
- R1: While `trip_n_i` is low, every bit of `gate_o` is at the off level in the same cycle, through a path that holds even when `clk` is stopped.
- R2: The off level of each gate output is the inverse of `pol_i`, and the on level equals `pol_i`. So with `pol_i`=1 off is 0, and with `pol_i`=0 off is 1.
- R3: When no shutdown is active, `gate_o[i]` takes the on level when `pwm_on_i[i]` is 1 and the off level when it is 0.
- R4: An I/O line `gpio_i[k]` is asserted when low. It forces all gates off at once exactly like the trip pin when mask bit k is 1. When mask bit k is 0, the line has no effect on any output.
- R5: The 12-bit enable mask resets to all zeros. It is loaded from `mask_wdata_i` on a rising edge where `mask_we_i` is 1, and its new value takes effect right after that edge.
- R6: The trip pin and the I/O lines pass through a two-stage synchronizer. A hardware source that is present before rising edge n sets the latch (`timer_rst_o`=1) after edge n+2.
- R7: A one-cycle `sw_trip_i` pulse sets the latch at the next rising edge.
- R8: While the latch is set, `timer_rst_o` is 1 and all gates stay at the off level, even after every source has released.
- R9: The latch clears at a rising edge with `sw_clear_i`=1 only if neither a set request nor a synchronized hardware source is present. A set request wins over a clear in the same cycle.
- R10: `irq_o` is 1 for exactly the one cycle in which the latch goes from clear to set. Set requests that arrive while the latch is already set give no pulse.
- R11: `trip_status_o` reports the level of `trip_n_i` delayed by the two synchronizer stages.
- R12: After reset, `timer_rst_o`=0, `irq_o`=0 and `trip_status_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| pol_i | input | 1 | Gate polarity; the on level of the gate outputs |
| pwm_on_i | input | 6 | Switch commands from the timer, 1 = device on |
| trip_n_i | input | 1 | Dedicated trip pin, active low |
| gpio_i | input | 12 | General I/O lines, asserted when low |
| mask_we_i | input | 1 | Load strobe for the I/O trip enable mask |
| mask_wdata_i | input | 12 | New enable mask value |
| sw_trip_i | input | 1 | Software shutdown write strobe |
| sw_clear_i | input | 1 | Software re-enable write strobe |
| gate_o | output | 6 | Gate drive outputs after shutdown forcing |
| timer_rst_o | output | 1 | Shutdown latch state; holds the PWM timer in reset |
| irq_o | output | 1 | Single-cycle shutdown interrupt |
| trip_status_o | output | 1 | Synchronized trip pin level |

## Verification
The clocked properties assume that `pol_i`, `pwm_on_i`, the trip pin and the I/O lines are stable around each rising edge. That lets the combinational forcing of the gates be sampled at the edge. The stimulus changes all inputs one nanosecond after a falling edge, so this holds. The one deliberate exception is a window in which the clock is halted and the trip pin is toggled; no edge is sampled in that window. The software strobes are taken to be single-cycle writes, and the bench drives them that way.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;

  // Number of gate outputs: three phases, high and low side each.
  localparam int unsigned PTC_GATES = 6;
  // General I/O lines that may be routed to the trip function.
  localparam int unsigned PTC_LINES = 12;
  // Synchronizer depth for the pin inputs.
  localparam int unsigned PTC_SYNC  = 2;

  typedef enum logic {
    LATCH_RUN  = 1'b0,
    LATCH_TRIP = 1'b1
  } latch_state_e;

endpackage

// File: rtl/pwm_trip_sync.sv
module pwm_trip_sync #(
  parameter int unsigned     WIDTH   = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = din_i;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {STAGES{RST_VAL}};
    end else begin
      stage_q <= stage_d;
    end
  end

  assign dout_o = stage_q[STAGES-1];

endmodule

// File: rtl/pwm_trip_detect.sv
module pwm_trip_detect #(
  parameter int unsigned NUM_LINES = 12
) (
  input  logic                 trip_n_i,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic [NUM_LINES-1:0] mask_i,
  output logic                 req_o
);

  logic [NUM_LINES-1:0] line_hit;

  // Each enabled line counts as a trip when low.
  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    assign line_hit[k] = mask_i[k] & ~line_i[k];
  end

  assign req_o = ~trip_n_i | (|line_hit);

endmodule

// File: rtl/pwm_trip_latch.sv
module pwm_trip_latch
  import pwm_trip_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hw_req_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  output logic shut_o,
  output logic irq_o
);

  latch_state_e state_q, state_d;
  logic         irq_q, irq_d;
  logic         set_req;

  assign set_req = hw_req_i | sw_set_i;

  always_comb begin
    state_d = state_q;
    if (set_req) begin
      state_d = LATCH_TRIP;
    end else if (sw_clr_i) begin
      state_d = LATCH_RUN;
    end
    irq_d = set_req & (state_q == LATCH_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LATCH_RUN;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
    end
  end

  assign shut_o = (state_q == LATCH_TRIP);
  assign irq_o  = irq_q;

endmodule

// File: rtl/pwm_trip_gate.sv
module pwm_trip_gate #(
  parameter int unsigned NUM_OUT = 6
) (
  input  logic               pol_i,
  input  logic               force_off_i,
  input  logic [NUM_OUT-1:0] on_i,
  output logic [NUM_OUT-1:0] gate_o
);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    assign gate_o[i] = (on_i[i] & ~force_off_i) ? pol_i : ~pol_i;
  end

endmodule

// File: rtl/pwm_trip_ctrl.sv
module pwm_trip_ctrl
  import pwm_trip_pkg::*;
#(
  parameter int unsigned NUM_OUT     = PTC_GATES,
  parameter int unsigned NUM_GPIO    = PTC_LINES,
  parameter int unsigned SYNC_STAGES = PTC_SYNC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pol_i,
  input  logic [NUM_OUT-1:0]  pwm_on_i,
  input  logic                trip_n_i,
  input  logic [NUM_GPIO-1:0] gpio_i,
  input  logic                mask_we_i,
  input  logic [NUM_GPIO-1:0] mask_wdata_i,
  input  logic                sw_trip_i,
  input  logic                sw_clear_i,
  output logic [NUM_OUT-1:0]  gate_o,
  output logic                timer_rst_o,
  output logic                irq_o,
  output logic                trip_status_o
);

  localparam int unsigned PIN_W = NUM_GPIO + 1;

  logic [NUM_GPIO-1:0] mask_q, mask_d;
  logic [PIN_W-1:0]    pins_sync;
  logic                hw_req_raw;
  logic                hw_req_sync;
  logic                shut;

  // Enable mask for the I/O trip lines.
  always_comb begin
    mask_d = mask_q;
    if (mask_we_i) begin
      mask_d = mask_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else begin
      mask_q <= mask_d;
    end
  end

  // Unclocked detection: drives the gates directly.
  pwm_trip_detect #(.NUM_LINES(NUM_GPIO)) u_det_raw (
    .trip_n_i (trip_n_i),
    .line_i   (gpio_i),
    .mask_i   (mask_q),
    .req_o    (hw_req_raw)
  );

  // Clocked copy of the pins, idle level high.
  pwm_trip_sync #(
    .WIDTH   (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({PIN_W{1'b1}})
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din_i  ({trip_n_i, gpio_i}),
    .dout_o (pins_sync)
  );

  pwm_trip_detect #(.NUM_LINES(NUM_GPIO)) u_det_sync (
    .trip_n_i (pins_sync[NUM_GPIO]),
    .line_i   (pins_sync[NUM_GPIO-1:0]),
    .mask_i   (mask_q),
    .req_o    (hw_req_sync)
  );

  pwm_trip_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_req_i (hw_req_sync),
    .sw_set_i (sw_trip_i),
    .sw_clr_i (sw_clear_i),
    .shut_o   (shut),
    .irq_o    (irq_o)
  );

  pwm_trip_gate #(.NUM_OUT(NUM_OUT)) u_gate (
    .pol_i       (pol_i),
    .force_off_i (hw_req_raw | shut),
    .on_i        (pwm_on_i),
    .gate_o      (gate_o)
  );

  assign timer_rst_o   = shut;
  assign trip_status_o = pins_sync[NUM_GPIO];

endmodule

// File: rtl/pwm_trip_ctrl_chk.sv
module pwm_trip_ctrl_chk #(
  parameter int unsigned NUM_OUT  = 6,
  parameter int unsigned NUM_GPIO = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pol_i,
  input logic                trip_n_i,
  input logic [NUM_GPIO-1:0] gpio_i,
  input logic [NUM_GPIO-1:0] mask_q,
  input logic                sw_trip_i,
  input logic                sw_clear_i,
  input logic [NUM_OUT-1:0]  gate_o,
  input logic                timer_rst_o,
  input logic                irq_o
);

  AST_TRIP_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_n_i |-> gate_o == {NUM_OUT{~pol_i}}); // R1

  AST_LINE_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~gpio_i & mask_q)) |-> gate_o == {NUM_OUT{~pol_i}}); // R4

  AST_SW_SETS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    sw_trip_i |=> timer_rst_o); // R7

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    timer_rst_o && !sw_clear_i |=> timer_rst_o); // R8

  AST_OFF_WHILE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    timer_rst_o |-> gate_o == {NUM_OUT{~pol_i}}); // R8

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o); // R10

  AST_IRQ_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timer_rst_o) |-> irq_o); // R10

  AST_IRQ_WITH_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> timer_rst_o); // R10

endmodule

bind pwm_trip_ctrl pwm_trip_ctrl_chk #(
  .NUM_OUT  (NUM_OUT),
  .NUM_GPIO (NUM_GPIO)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pol_i       (pol_i),
  .trip_n_i    (trip_n_i),
  .gpio_i      (gpio_i),
  .mask_q      (mask_q),
  .sw_trip_i   (sw_trip_i),
  .sw_clear_i  (sw_clear_i),
  .gate_o      (gate_o),
  .timer_rst_o (timer_rst_o),
  .irq_o       (irq_o)
);

// File: tb/pwm_trip_ctrl_bench.sv
`timescale 1ns/1ps
module pwm_trip_ctrl_bench;

  localparam int NO = 6;
  localparam int NG = 12;

  logic          clk = 1'b0;
  logic          clk_run = 1'b1;
  logic          rst_n;
  logic          pol_i;
  logic [NO-1:0] pwm_on_i;
  logic          trip_n_i;
  logic [NG-1:0] gpio_i;
  logic          mask_we_i;
  logic [NG-1:0] mask_wdata_i;
  logic          sw_trip_i;
  logic          sw_clear_i;
  logic [NO-1:0] gate_o;
  logic          timer_rst_o;
  logic          irq_o;
  logic          trip_status_o;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  chk_en = 0;

  // Reference model state
  logic [NG:0]   pipe[$];
  logic [NG-1:0] m_mask;
  logic          m_shut, m_irq, m_stat;

  pwm_trip_ctrl u_pwm_trip_ctrl (
    .clk(clk), .rst_n(rst_n), .pol_i(pol_i), .pwm_on_i(pwm_on_i),
    .trip_n_i(trip_n_i), .gpio_i(gpio_i), .mask_we_i(mask_we_i),
    .mask_wdata_i(mask_wdata_i), .sw_trip_i(sw_trip_i),
    .sw_clear_i(sw_clear_i), .gate_o(gate_o), .timer_rst_o(timer_rst_o),
    .irq_o(irq_o), .trip_status_o(trip_status_o)
  );

  always begin
    #10;
    if (clk_run) clk = ~clk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NO-1:0] exp_gate();
    logic hw;
    logic [NO-1:0] g;
    hw = (trip_n_i == 1'b0) || ((~gpio_i & m_mask) != '0);
    for (int i = 0; i < NO; i++)
      g[i] = (pwm_on_i[i] && !(hw || m_shut)) ? pol_i : ~pol_i;
    return g;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe.delete();
      pipe.push_back({(NG+1){1'b1}});
      pipe.push_back({(NG+1){1'b1}});
      m_mask = '0; m_shut = 0; m_irq = 0; m_stat = 1;
    end else begin
      logic hw, setr;
      hw   = (pipe[0][NG] == 1'b0) || ((~pipe[0][NG-1:0] & m_mask) != '0);
      setr = hw || sw_trip_i;
      m_irq = setr && !m_shut;
      if (setr) m_shut = 1;
      else if (sw_clear_i && !hw) m_shut = 0;
      if (mask_we_i) m_mask = mask_wdata_i;
      void'(pipe.pop_front());
      pipe.push_back({trip_n_i, gpio_i});
      m_stat = pipe[0][NG];
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      chk("R3 gate_o", gate_o, exp_gate());
      chk("R8 timer_rst_o", timer_rst_o, m_shut);
      chk("R10 irq_o", irq_o, m_irq);
      chk("R11 trip_status_o", trip_status_o, m_stat);
    end
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; pol_i = 1; pwm_on_i = 6'b101010; trip_n_i = 1; gpio_i = '1;
    mask_we_i = 0; mask_wdata_i = '0; sw_trip_i = 0; sw_clear_i = 0;
    tick(3);
    // R12 reset state
    chk("R12 timer_rst_o", timer_rst_o, 0);
    chk("R12 irq_o", irq_o, 0);
    chk("R12 trip_status_o", trip_status_o, 1);
    chk("R12 gate_o", gate_o, 6'b101010);
    rst_n = 1; chk_en = 1;
    tick(2);

    // R3 pass-through with several patterns and both polarities
    pwm_on_i = 6'b010101; tick(1);
    pwm_on_i = 6'b111000; pol_i = 0; tick(1);
    #1 chk("R2 gate_o pol=0 passthrough", gate_o, 6'b000111);
    pwm_on_i = 6'b000000; tick(1);
    pwm_on_i = 6'b111111; pol_i = 1; tick(2);

    // R1 trip pin: immediate force, then R6 latch timing
    trip_n_i = 0;
    #1 chk("R1 gate_o immediate", gate_o, 6'b000000);
    tick(1);
    trip_n_i = 1;
    chk("R6 not yet latched", timer_rst_o, 0);
    tick(1);
    chk("R6 not yet latched 2", timer_rst_o, 0);
    chk("R11 status low", trip_status_o, 0);
    tick(1);
    chk("R6 latched after edge n+2", timer_rst_o, 1);
    chk("R10 irq pulse", irq_o, 1);
    tick(3);
    chk("R8 held off", gate_o, 6'b000000);
    pol_i = 0;
    #1 chk("R2 off level pol=0", gate_o, 6'b111111);
    pol_i = 1;

    // R9 clear with no source
    sw_clear_i = 1; tick(1); sw_clear_i = 0;
    chk("R9 cleared", timer_rst_o, 0);
    tick(2);

    // R4 masked line has no effect
    gpio_i[3] = 0; tick(4);
    chk("R4 masked line ignored", timer_rst_o, 0);
    chk("R4 masked line gates", gate_o, 6'b111111);
    // R5 enable mask bit 3
    mask_we_i = 1; mask_wdata_i = 12'h008; tick(1); mask_we_i = 0;
    chk("R5 mask forces gates", gate_o, 6'b000000);
    tick(3);
    chk("R4 line latched", timer_rst_o, 1);
    sw_clear_i = 1; tick(1); sw_clear_i = 0;
    chk("R9 clear refused while asserted", timer_rst_o, 1);
    gpio_i[3] = 1; tick(3);
    sw_clear_i = 1; tick(1); sw_clear_i = 0;
    chk("R9 clear after release", timer_rst_o, 0);
    tick(2);

    // R7 software trip, R10 no second pulse, R9 set beats clear
    sw_trip_i = 1; tick(1); sw_trip_i = 0;
    chk("R7 sw trip latched", timer_rst_o, 1);
    chk("R10 sw irq", irq_o, 1);
    tick(1);
    sw_trip_i = 1; tick(1); sw_trip_i = 0;
    chk("R10 no repeat irq", irq_o, 0);
    sw_trip_i = 1; sw_clear_i = 1; tick(1); sw_trip_i = 0; sw_clear_i = 0;
    chk("R9 set wins", timer_rst_o, 1);
    sw_clear_i = 1; tick(1); sw_clear_i = 0;
    chk("R9 cleared again", timer_rst_o, 0);
    tick(2);

    // R1 with the clock halted
    clk_run = 0;
    #5 trip_n_i = 0;
    #3 chk("R1 no clock forced off", gate_o, 6'b000000);
    gpio_i[11] = 0; trip_n_i = 1;
    #3 chk("R4 unmasked line no clock", gate_o, 6'b111111);
    mask_wdata_i = 12'h800;
    gpio_i[11] = 1;
    #5 clk_run = 1;
    tick(3);
    chk("R6 short pulse unseen", timer_rst_o, 0);

    // R4 line 11 with mask
    mask_we_i = 1; tick(1); mask_we_i = 0;
    gpio_i[11] = 0; pwm_on_i = 6'b110011;
    #1 chk("R4 line 11 immediate", gate_o, 6'b000000);
    tick(1); gpio_i[11] = 1; tick(3);
    chk("R4 line 11 latched", timer_rst_o, 1);
    sw_clear_i = 1; tick(1); sw_clear_i = 0;
    tick(2);
    chk("R3 resumed", gate_o, 6'b110011);

    chk_en = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule